// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to 32 pins. It sits behind an APB slave and uses no wait states. Each bit position of every register is one pin. Input pins reach the bus through a two-stage synchronizer. Software drives the pins through an output data register and a direction mask. Every attribute has two addresses: one where a written one sets the matching bits and one where a written one clears them. A read-modify-write is therefore never needed, and a write to one pin cannot disturb its neighbours.

Each pin has its own interrupt detector, with three settings. The first picks level or edge sensitivity. The second picks the polarity: active high or rising, against active low or falling. The third is an any-edge override that makes an edge pin fire on both transitions. Level status follows the synchronized pin. Edge status is latched until software acknowledges it. The enabled status bits are ORed into a single interrupt request. A loopback mode feeds the output register back into the input path and releases the pads, so software can test the port without external wiring.

Top module: `apb_gpio_irq`

## Requirements
- R1: After reset the output, direction, enable, edge, polarity, any-edge and loopback registers are all zero. `pin_oe`, `pin_out` and `irq` are low, and `pready` is high.
- R2: Writing ones at word 0 (byte offset 0x00) sets those bits of the output register. Writing ones at word 1 (0x04) clears them. Zero bits leave the output register unchanged, and it appears directly on `pin_out`.
- R3: Writing ones at word 2 (0x08) makes those pins outputs, and writing ones at word 3 (0x0C) makes them inputs. Reading either address returns the direction mask, where 1 means output, and that mask drives `pin_oe`.
- R4: Reading word 0 returns the pin inputs after a two-flop synchronizer. A pin change becomes visible to the interrupt logic two rising clock edges after it is applied.
- R5: The interrupt enable is set at word 4 (0x10) and cleared at word 5 (0x14), and both addresses read the mask. `irq` is the OR over all pins of status AND enable, so a pin whose enable bit is 0 never raises `irq`.
- R6: Writing ones at word 7 (0x1C) makes pins level-sensitive. Their status (read at word 1) then equals the synchronized input when polarity is 1 and its inverse when polarity is 0. Polarity is set at word 8 (0x20) and cleared at word 9 (0x24).
- R7: Writing ones at word 6 (0x18) makes pins edge-sensitive. Words 6 and 7 both read the edge mask. An edge pin latches status on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge is ignored, and the latched status holds until it is acknowledged.
- R8: The any-edge mask is set at word 10 (0x28) and cleared at word 11 (0x2C), and both addresses read the mask. When set, an edge pin latches on both edges regardless of polarity.
- R9: Writing ones at word 12 (0x30) clears latched edge status for those pins. The write has no effect on level-sensitive status.
- R10: Bit 0 of word 13 (0x34) selects loopback. In loopback the output register replaces `pin_in` at the synchronizer input and `pin_oe` is forced to zero. Clearing the bit restores normal mode.
- R11: Words 14 and 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address, word aligned |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during the access phase |
| pready | output | 1 | Always high (no wait states) |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Output data register |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest behaviour to reach is the interaction between a latched edge event and the rest of the configuration. Cases include an event captured while its enable is still off, the opposite edge arriving on a latched pin, and an acknowledge aimed at a pin in level mode. The bench sweeps every pin in turn and rotates through five detector settings: level high, level low, rising, falling and any-edge. It toggles only the pin under test and verifies its status bit and `irq` after each transition. The synchronizer latency is pinned down by sampling `irq` one edge and then two edges after a level-high pin rises.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // word index of each register; the index is address bits [ADDR_W-1:2]
   typedef enum logic [3:0] {
      RG_DATA    = 4'd0,   // read: synced inputs, write: set outputs
      RG_STAT    = 4'd1,   // read: irq status,    write: clear outputs
      RG_DIR_OUT = 4'd2,
      RG_DIR_IN  = 4'd3,
      RG_IEN_SET = 4'd4,
      RG_IEN_CLR = 4'd5,
      RG_EDGE    = 4'd6,
      RG_LEVEL   = 4'd7,
      RG_POL_SET = 4'd8,
      RG_POL_CLR = 4'd9,
      RG_ANY_SET = 4'd10,
      RG_ANY_CLR = 4'd11,
      RG_ACK     = 4'd12,
      RG_CTRL    = 4'd13
   } gpio_reg_e;

   localparam int unsigned CTRL_LOOP_BIT = 0;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned N      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] synced,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);

   logic [STAGES-1:0][N-1:0] chain_q;
   logic [N-1:0]             prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign synced = chain_q[STAGES-1];
   assign rise   = synced & ~prev_q;
   assign fall   = ~synced & prev_q;

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise,
   input  logic fall,
   input  logic edge_md,
   input  logic pol,
   input  logic any,
   input  logic ack,
   output logic stat
);

   logic latch_q;
   logic hit;

   always_comb begin
      if (any) hit = rise | fall;
      else     hit = pol ? rise : fall;
   end

   // a new event wins over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q <= 1'b0;
      else if (!edge_md) latch_q <= 1'b0;
      else if (hit)      latch_q <= 1'b1;
      else if (ack)      latch_q <= 1'b0;
   end

   assign stat = edge_md ? latch_q : (pol ? lvl : ~lvl);

   // R7
   latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_md && $past(edge_md) && $past(latch_q) && !$past(ack)) |-> latch_q);

   // R8
   any_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_md && any && (rise || fall)) |=> (latch_q || !edge_md));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned N      = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned AW     = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          psel,
   input  logic          penable,
   input  logic          pwrite,
   input  logic [AW-1:0] paddr,
   input  logic [DW-1:0] pwdata,
   output logic [DW-1:0] prdata,
   input  logic [N-1:0]  sync_in,
   input  logic [N-1:0]  irq_stat,
   output logic [N-1:0]  out_q,
   output logic [N-1:0]  dir_q,
   output logic [N-1:0]  ien_q,
   output logic [N-1:0]  edge_q,
   output logic [N-1:0]  pol_q,
   output logic [N-1:0]  any_q,
   output logic          loop_q,
   output logic [N-1:0]  ack_bits
);

   localparam int unsigned IDX_W = AW - 2;

   logic             wr_en;
   logic [IDX_W-1:0] widx;
   logic [N-1:0]     wbits;
   logic             unused_bits;

   assign wr_en       = psel & penable & pwrite;
   assign widx        = paddr[AW-1:2];
   assign wbits       = pwdata[N-1:0];
   assign unused_bits = ^{paddr[1:0], pwdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         ien_q  <= '0;
         edge_q <= '0;
         pol_q  <= '0;
         any_q  <= '0;
         loop_q <= 1'b0;
      end else if (wr_en) begin
         case (widx)
            IDX_W'(RG_DATA):    out_q  <= out_q  |  wbits;
            IDX_W'(RG_STAT):    out_q  <= out_q  & ~wbits;
            IDX_W'(RG_DIR_OUT): dir_q  <= dir_q  |  wbits;
            IDX_W'(RG_DIR_IN):  dir_q  <= dir_q  & ~wbits;
            IDX_W'(RG_IEN_SET): ien_q  <= ien_q  |  wbits;
            IDX_W'(RG_IEN_CLR): ien_q  <= ien_q  & ~wbits;
            IDX_W'(RG_EDGE):    edge_q <= edge_q |  wbits;
            IDX_W'(RG_LEVEL):   edge_q <= edge_q & ~wbits;
            IDX_W'(RG_POL_SET): pol_q  <= pol_q  |  wbits;
            IDX_W'(RG_POL_CLR): pol_q  <= pol_q  & ~wbits;
            IDX_W'(RG_ANY_SET): any_q  <= any_q  |  wbits;
            IDX_W'(RG_ANY_CLR): any_q  <= any_q  & ~wbits;
            IDX_W'(RG_CTRL):    loop_q <= pwdata[CTRL_LOOP_BIT];
            default: ;
         endcase
      end
   end

   assign ack_bits = (wr_en && widx == IDX_W'(RG_ACK)) ? wbits : '0;

   logic [N-1:0] rd_pins;

   always_comb begin
      rd_pins = '0;
      prdata  = '0;
      case (widx)
         IDX_W'(RG_DATA):                      rd_pins = sync_in;
         IDX_W'(RG_STAT):                      rd_pins = irq_stat;
         IDX_W'(RG_DIR_OUT), IDX_W'(RG_DIR_IN): rd_pins = dir_q;
         IDX_W'(RG_IEN_SET), IDX_W'(RG_IEN_CLR): rd_pins = ien_q;
         IDX_W'(RG_EDGE), IDX_W'(RG_LEVEL):     rd_pins = edge_q;
         IDX_W'(RG_POL_SET), IDX_W'(RG_POL_CLR): rd_pins = pol_q;
         IDX_W'(RG_ANY_SET), IDX_W'(RG_ANY_CLR): rd_pins = any_q;
         default:                              rd_pins = '0;
      endcase
      prdata[N-1:0] = rd_pins;
      if (widx == IDX_W'(RG_CTRL)) prdata[CTRL_LOOP_BIT] = loop_q;
   end

   // R2
   out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == IDX_W'(RG_DATA)) |=> ((out_q & $past(wbits)) == $past(wbits)));

   // R2
   out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == IDX_W'(RG_STAT)) |=> ((out_q & $past(wbits)) == '0));

   // R3
   dir_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == IDX_W'(RG_DIR_IN)) |=> ((dir_q & $past(wbits)) == '0));

endmodule

// File: rtl/apb_gpio_irq.sv
module apb_gpio_irq
   import gpio_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);

   generate
      if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
         $error("apb_gpio_irq: NPINS must be in 1..DATA_W");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("apb_gpio_irq: ADDR_W must cover 14 word registers");
      end
   endgenerate

   logic [NPINS-1:0] out_q, dir_q, ien_q, edge_q, pol_q, any_q, ack_bits;
   logic [NPINS-1:0] raw, synced, rise, fall, stat;
   logic             loop_q;

   gpio_regs #(.N(NPINS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
      .clk      (pclk),
      .rst_n    (presetn),
      .psel     (psel),
      .penable  (penable),
      .pwrite   (pwrite),
      .paddr    (paddr),
      .pwdata   (pwdata),
      .prdata   (prdata),
      .sync_in  (synced),
      .irq_stat (stat),
      .out_q    (out_q),
      .dir_q    (dir_q),
      .ien_q    (ien_q),
      .edge_q   (edge_q),
      .pol_q    (pol_q),
      .any_q    (any_q),
      .loop_q   (loop_q),
      .ack_bits (ack_bits)
   );

   assign raw = loop_q ? out_q : pin_in;

   gpio_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (pclk),
      .rst_n  (presetn),
      .raw    (raw),
      .synced (synced),
      .rise   (rise),
      .fall   (fall)
   );

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         gpio_irq_cell u_cell (
            .clk     (pclk),
            .rst_n   (presetn),
            .lvl     (synced[p]),
            .rise    (rise[p]),
            .fall    (fall[p]),
            .edge_md (edge_q[p]),
            .pol     (pol_q[p]),
            .any     (any_q[p]),
            .ack     (ack_bits[p]),
            .stat    (stat[p])
         );
      end
   endgenerate

   assign irq     = |(stat & ien_q);
   assign pin_out = out_q;
   assign pin_oe  = loop_q ? '0 : dir_q;
   assign pready  = 1'b1;

   // R5
   irq_mask_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (ien_q == '0) |-> !irq);

   // R10
   loop_pad_chk: assert property (@(posedge pclk) disable iff (!presetn)
      loop_q |-> (pin_oe == '0));

endmodule

// File: tb/apb_gpio_irq_bench.sv
module apb_gpio_irq_bench;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [5:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 pclk = ~pclk;

   apb_gpio_irq u_apb_gpio_irq (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = 6'(idx * 4); pwdata = d; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = 6'(idx * 4); penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge pclk);
      @(negedge pclk);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      @(negedge pclk);

      // R1 reset state
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      chk("R1 pready", {31'h0, pready}, 32'h1);
      foreach (v[k]) begin end
      for (int r = 2; r <= 13; r += 1) begin
         if (r == 12) continue;
         rd(r, v);
         chk($sformatf("R1 reg word %0d", r), v, 32'h0);
      end

      // R11 unmapped words
      rd(14, v); chk("R11 word 14", v, 32'h0);
      rd(15, v); chk("R11 word 15", v, 32'h0);

      // R2 output set/clear
      wr(0, 32'hA5C3_0F01); chk("R2 set", pin_out, 32'hA5C3_0F01);
      wr(0, 32'h0);         chk("R2 zero set no effect", pin_out, 32'hA5C3_0F01);
      wr(1, 32'h0000_0F00); chk("R2 clear", pin_out, 32'hA5C3_0001);
      wr(1, 32'h0);         chk("R2 zero clear no effect", pin_out, 32'hA5C3_0001);
      wr(1, 32'hFFFF_FFFF); chk("R2 clear all", pin_out, 32'h0);

      // R3 direction
      wr(2, 32'hF0F0_1234); chk("R3 oe after out", pin_oe, 32'hF0F0_1234);
      rd(2, v); chk("R3 read word 2", v, 32'hF0F0_1234);
      wr(3, 32'h0000_1230); chk("R3 oe after in", pin_oe, 32'hF0F0_0004);
      rd(3, v); chk("R3 read word 3", v, 32'hF0F0_0004);

      // R4 synchronized input readback
      pin_in = 32'h8001_7E02;
      settle(3);
      rd(0, v); chk("R4 input read", v, 32'h8001_7E02);

      // R10 loopback
      wr(13, 32'h1);
      rd(13, v); chk("R10 ctrl readback", v, 32'h1);
      chk("R10 pads released", pin_oe, 32'h0);
      wr(0, 32'h1234_5678);
      settle(3);
      rd(0, v); chk("R10 loopback input", v, 32'h1234_5678);
      wr(13, 32'h0);
      settle(3);
      rd(0, v); chk("R10 normal input", v, 32'h8001_7E02);
      chk("R10 oe restored", pin_oe, 32'hF0F0_0004);
      wr(1, 32'hFFFF_FFFF);
      wr(3, 32'hFFFF_FFFF);
      pin_in = 32'h0;
      settle(3);

      // per-pin sweep across five detector settings
      for (int i = 0; i < 32; i++) begin
         logic [31:0] b;
         int m;
         b = 32'h1 << i;
         m = i % 5;
         case (m)
            0: begin // level, active high
               wr(7, b); wr(8, b); wr(4, b);
               @(negedge pclk);
               pin_in = b;
               @(posedge pclk); @(negedge pclk);
               chk($sformatf("R4 pin %0d one edge", i), {31'h0, irq}, 32'h0);
               @(posedge pclk); @(negedge pclk);
               chk($sformatf("R4 pin %0d two edges", i), {31'h0, irq}, 32'h1);
               rd(1, v); chk($sformatf("R6 pin %0d level high", i), v & b, b);
               wr(12, b);
               rd(1, v); chk($sformatf("R9 pin %0d ack ignores level", i), v & b, b);
               pin_in = 32'h0; settle(3);
               chk($sformatf("R6 pin %0d level drop", i), {31'h0, irq}, 32'h0);
            end
            1: begin // level, active low
               wr(7, b); wr(9, b); wr(4, b);
               settle(3);
               chk($sformatf("R6 pin %0d low active", i), {31'h0, irq}, 32'h1);
               pin_in = b; settle(3);
               chk($sformatf("R6 pin %0d low inactive", i), {31'h0, irq}, 32'h0);
               pin_in = 32'h0; settle(3);
               wr(12, b);
               chk($sformatf("R9 pin %0d ack ignores low level", i), {31'h0, irq}, 32'h1);
            end
            2: begin // rising edge
               wr(6, b); wr(8, b);
               pin_in = b; settle(3);
               rd(1, v); chk($sformatf("R7 pin %0d rise latched", i), v & b, b);
               chk($sformatf("R5 pin %0d masked", i), {31'h0, irq}, 32'h0);
               wr(4, b);
               chk($sformatf("R5 pin %0d enabled", i), {31'h0, irq}, 32'h1);
               pin_in = 32'h0; settle(3);
               rd(1, v); chk($sformatf("R7 pin %0d held", i), v & b, b);
               wr(12, b);
               rd(1, v); chk($sformatf("R9 pin %0d ack edge", i), v & b, 32'h0);
               chk($sformatf("R9 pin %0d irq cleared", i), {31'h0, irq}, 32'h0);
            end
            3: begin // falling edge
               wr(6, b); wr(9, b); wr(4, b);
               pin_in = b; settle(3);
               rd(1, v); chk($sformatf("R7 pin %0d rise ignored", i), v & b, 32'h0);
               pin_in = 32'h0; settle(3);
               rd(1, v); chk($sformatf("R7 pin %0d fall latched", i), v & b, b);
               wr(12, b);
               chk($sformatf("R9 pin %0d fall acked", i), {31'h0, irq}, 32'h0);
            end
            default: begin // any edge, polarity set
               wr(6, b); wr(8, b); wr(10, b); wr(4, b);
               rd(4, v);  chk($sformatf("R5 pin %0d enable via set", i), v, b);
               rd(5, v);  chk($sformatf("R5 pin %0d enable via clear", i), v, b);
               rd(7, v);  chk($sformatf("R7 pin %0d edge mask", i), v, b);
               rd(11, v); chk($sformatf("R8 pin %0d any mask", i), v, b);
               pin_in = b; settle(3);
               rd(1, v); chk($sformatf("R8 pin %0d any rise", i), v & b, b);
               wr(12, b);
               pin_in = 32'h0; settle(3);
               rd(1, v); chk($sformatf("R8 pin %0d any fall", i), v & b, b);
               wr(12, b);
            end
         endcase
         // return to defaults
         wr(5, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
         wr(9, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF);
         pin_in = 32'h0; settle(3);
         chk($sformatf("R5 pin %0d idle irq", i), {31'h0, irq}, 32'h0);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge pclk);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

endmodule